// File: doc/BRIEF.md
# Hardwired Control Step Sequencer

This block is the control unit of a small single-bus processor, built as fixed logic rather than from a stored control program. A 3-bit step counter moves through the phases of one instruction. A 3-to-8 decoder turns the counter into one-hot step terms. Combinational equations then combine those step terms with the decoded opcode and the negative flag. From that they produce the result-register load strobe, the end-of-instruction strobe and the fetch-phase strobes.

The first three steps fetch the instruction word. In the first step the program counter drives the address register, and the ALU forms the incremented PC into the result register. In the third step the memory data register drives the instruction register. Three operations are decoded: add, unconditional branch and branch-if-negative. How many steps an instruction takes depends on its opcode and, for the conditional branch, on the negative flag. When the end strobe fires, the next step is the first fetch step of a new instruction.

Top module: `ctl_step_seq`

## Requirements
- R1: A synchronous active-high reset puts the counter at the first step: `step_oh` = 8'h01 on the first clock edge with `rst` high.
- R2: With `run` high and `end_step` low, each rising clock edge moves the step one position forward: `step_oh` shifts left by one.
- R3: With `run` low, the step holds its value, and every control output keeps following the held step.
- R4: `step_oh` is always one-hot. Bit k is high when the counter holds k, so bit 0 is step 1 and bit 7 is step 8.
- R5: `zin` is high in step 1, in step 6 when the opcode is add, and in step 4 when the opcode is an unconditional branch.
- R6: Opcode 4'h1 (add) asserts `end_step` in step 7, so the instruction lasts seven steps.
- R7: Opcode 4'h2 (unconditional branch) asserts `end_step` in step 5.
- R8: Opcode 4'h3 (branch if negative) asserts `end_step` in step 5 when `flag_n` is 1, and in step 4 when `flag_n` is 0.
- R9: Any other opcode asserts `end_step` in step 4, so the fetch loop restarts.
- R10: `end_step` high with `run` high returns the step to step 1 (8'h01) at the next clock edge.
- R11: `mar_in`, `pc_out` and `alu_inc` are high only in step 1. `mdr_out` and `ir_in` are high only in step 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Step advance enable |
| opcode | input | 4 | Opcode field of the instruction register |
| flag_n | input | 1 | Negative condition flag |
| step_oh | output | 8 | One-hot step terms, bit 0 = step 1 |
| zin | output | 1 | Load the result register |
| end_step | output | 1 | Last step of the instruction |
| mar_in | output | 1 | Load the memory address register |
| pc_out | output | 1 | Program counter drives the bus |
| mdr_out | output | 1 | Memory data register drives the bus |
| ir_in | output | 1 | Load the instruction register |
| alu_inc | output | 1 | ALU selects PC increment |

## Verification
Every control output is combinational from the counter, the opcode and the flag. A change of opcode or flag is therefore due in the same cycle. A change of step is due one clock edge after `run` is sampled high. The bench drives its inputs on the falling edge and samples two nanoseconds later. It walks each instruction one step per cycle, comparing every output against the step it expects, and checks for step 1 one cycle after the expected end step. For the hold case, it samples repeatedly while `run` is low and expects no change.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam int STEP_W  = 3;
    localparam int N_STEPS = 1 << STEP_W;
    localparam int OP_W    = 4;

    localparam logic [OP_W-1:0] OP_ADD = 4'h1;
    localparam logic [OP_W-1:0] OP_BR  = 4'h2;
    localparam logic [OP_W-1:0] OP_BRN = 4'h3;

    // step index (0-based) of named steps
    localparam int S1 = 0;
    localparam int S3 = 2;
    localparam int S4 = 3;
    localparam int S5 = 4;
    localparam int S6 = 5;
    localparam int S7 = 6;

    typedef struct packed {
        logic add;
        logic br;
        logic brn;
        logic unk;
    } op_dec_t;

    typedef struct packed {
        logic zin;
        logic fin;
        logic mar_in;
        logic pc_out;
        logic mdr_out;
        logic ir_in;
        logic alu_inc;
    } ctrl_t;
endpackage

// File: rtl/ctl_step_counter.sv
module ctl_step_counter
    import ctl_pkg::*;
#(
    parameter int W = STEP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         fin,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (run)
            cnt <= fin ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/ctl_step_decoder.sv
module ctl_step_decoder
    import ctl_pkg::*;
#(
    parameter int W = STEP_W,
    localparam int N = 1 << W
) (
    input  logic [W-1:0] cnt,
    output logic [N-1:0] oh
);
    for (genvar i = 0; i < N; i++) begin : g_term
        assign oh[i] = (cnt == W'(i));
    end
endmodule

// File: rtl/ctl_op_decoder.sv
module ctl_op_decoder
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_dec_t         dec
);
    always_comb begin
        dec = '0;
        unique case (opcode)
            OP_ADD:  dec.add = 1'b1;
            OP_BR:   dec.br  = 1'b1;
            OP_BRN:  dec.brn = 1'b1;
            default: dec.unk = 1'b1;
        endcase
    end
endmodule

// File: rtl/ctl_signal_logic.sv
module ctl_signal_logic
    import ctl_pkg::*;
(
    input  logic [N_STEPS-1:0] t,
    input  op_dec_t            dec,
    input  logic               flag_n,
    output ctrl_t              ctl
);
    always_comb begin
        ctl.zin     = t[S1] | (t[S6] & dec.add) | (t[S4] & dec.br);
        ctl.fin     = (t[S7] & dec.add) | (t[S5] & dec.br)
                    | (((t[S5] & flag_n) | (t[S4] & ~flag_n)) & dec.brn)
                    | (t[S4] & dec.unk);
        ctl.mar_in  = t[S1];
        ctl.pc_out  = t[S1];
        ctl.alu_inc = t[S1];
        ctl.mdr_out = t[S3];
        ctl.ir_in   = t[S3];
    end
endmodule

// File: rtl/ctl_step_seq.sv
module ctl_step_seq
    import ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [OP_W-1:0]    opcode,
    input  logic               flag_n,
    output logic [N_STEPS-1:0] step_oh,
    output logic               zin,
    output logic               end_step,
    output logic               mar_in,
    output logic               pc_out,
    output logic               mdr_out,
    output logic               ir_in,
    output logic               alu_inc
);
    logic [STEP_W-1:0] cnt;
    op_dec_t           dec;
    ctrl_t             ctl;

    ctl_step_counter #(.W(STEP_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .fin(ctl.fin), .cnt(cnt)
    );

    ctl_step_decoder #(.W(STEP_W)) u_sdec (
        .cnt(cnt), .oh(step_oh)
    );

    ctl_op_decoder u_odec (
        .opcode(opcode), .dec(dec)
    );

    ctl_signal_logic u_sig (
        .t(step_oh), .dec(dec), .flag_n(flag_n), .ctl(ctl)
    );

    assign zin      = ctl.zin;
    assign end_step = ctl.fin;
    assign mar_in   = ctl.mar_in;
    assign pc_out   = ctl.pc_out;
    assign mdr_out  = ctl.mdr_out;
    assign ir_in    = ctl.ir_in;
    assign alu_inc  = ctl.alu_inc;
endmodule

// File: rtl/ctl_step_seq_chk.sv
module ctl_step_seq_chk
    import ctl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               run,
    input logic [N_STEPS-1:0] step_oh,
    input logic               zin,
    input logic               end_step,
    input logic               mar_in,
    input logic               ir_in
);
    // R4
    onehot_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(step_oh) == 1);

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        run && !end_step |=> step_oh == ($past(step_oh) << 1));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        run && end_step |=> step_oh == N_STEPS'(1));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(step_oh));

    // R11
    fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mar_in |-> step_oh[S1]);

    // R11
    fetch_ir_chk: assert property (@(posedge clk) disable iff (rst)
        ir_in |-> step_oh[S3]);

    // R5
    zin_end_excl_chk: assert property (@(posedge clk) disable iff (rst)
        zin |-> !end_step);
endmodule

bind ctl_step_seq ctl_step_seq_chk u_chk (
    .clk(clk), .rst(rst), .run(run), .step_oh(step_oh), .zin(zin),
    .end_step(end_step), .mar_in(mar_in), .ir_in(ir_in)
);

// File: tb/ctl_step_seq_test.sv
`timescale 1ns/1ps
module ctl_step_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [3:0] opcode = 4'h0;
    logic       flag_n = 1'b0;
    logic [7:0] step_oh;
    logic zin, end_step, mar_in, pc_out, mdr_out, ir_in, alu_inc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctl_step_seq uut (
        .clk(clk), .rst(rst), .run(run), .opcode(opcode), .flag_n(flag_n),
        .step_oh(step_oh), .zin(zin), .end_step(end_step), .mar_in(mar_in),
        .pc_out(pc_out), .mdr_out(mdr_out), .ir_in(ir_in), .alu_inc(alu_inc)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int end_len(logic [3:0] op, logic n);
        case (op)
            4'h1:    return 7;
            4'h2:    return 5;
            4'h3:    return n ? 5 : 4;
            default: return 4;
        endcase
    endfunction

    function automatic logic exp_zin(int s, logic [3:0] op);
        return (s == 1) || (op == 4'h1 && s == 6) || (op == 4'h2 && s == 4);
    endfunction

    // checks every output at step s (1-based); called just after a falling edge
    task automatic chk_step(int s, logic [3:0] op, logic n);
        chk("R4 step_oh", step_oh, 32'(1) << (s - 1));
        chk("R5 zin", zin, exp_zin(s, op));
        chk("R6/R7/R8/R9 end_step", end_step, s == end_len(op, n));
        chk("R11 mar_in", mar_in, s == 1);
        chk("R11 pc_out", pc_out, s == 1);
        chk("R11 alu_inc", alu_inc, s == 1);
        chk("R11 mdr_out", mdr_out, s == 3);
        chk("R11 ir_in", ir_in, s == 3);
    endtask

    // R2 R10: walk one instruction from step 1, expect step 1 afterwards
    task automatic do_instr(logic [3:0] op, logic n);
        int len;
        len = end_len(op, n);
        opcode = op; flag_n = n; run = 1'b1;
        for (int s = 1; s <= len; s++) begin
            #2;
            chk_step(s, op, n);
            @(negedge clk);
        end
        #2;
        chk("R10 back to step 1", step_oh, 32'h01);
    endtask

    task automatic t_reset();
        rst = 1'b1; run = 1'b1;
        @(negedge clk); @(negedge clk);
        #2;
        chk("R1 reset step", step_oh, 32'h01);
        rst = 1'b0;
        @(negedge clk);
        #2;
        chk("R2 advance after reset", step_oh, 32'h02);
        rst = 1'b1;
        @(negedge clk);
        #2;
        chk("R1 reset mid-instruction", step_oh, 32'h01);
        rst = 1'b0;
        @(negedge clk);
        #2;
        chk("R1 stays at step 2 after release", step_oh, 32'h02);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_add();    do_instr(4'h1, 1'b0); do_instr(4'h1, 1'b1); endtask
    task automatic t_br();     do_instr(4'h2, 1'b0); do_instr(4'h2, 1'b1); endtask
    task automatic t_brn();    do_instr(4'h3, 1'b1); do_instr(4'h3, 1'b0); endtask
    task automatic t_unknown(); do_instr(4'h0, 1'b0); do_instr(4'hF, 1'b1); endtask

    // R3: freeze at step 3 of an add, then resume
    task automatic t_hold();
        opcode = 4'h1; flag_n = 1'b0; run = 1'b1;
        @(negedge clk); @(negedge clk);
        run = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #2;
            chk("R3 hold step", step_oh, 32'h04);
            chk("R3 hold mdr_out", mdr_out, 1'b1);
            chk("R3 hold ir_in", ir_in, 1'b1);
        end
        run = 1'b1;
        for (int s = 3; s <= 7; s++) begin
            #2;
            chk_step(s, 4'h1, 1'b0);
            @(negedge clk);
        end
        #2;
        chk("R10 step 1 after held add", step_oh, 32'h01);
        // R3: hold on the end step of an unknown opcode, no restart
        opcode = 4'h9; run = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        run = 1'b0;
        @(negedge clk); @(negedge clk);
        #2;
        chk("R3 hold on end step", step_oh, 32'h08);
        chk("R3 R9 end follows held step", end_step, 1'b1);
        run = 1'b1;
        @(negedge clk);
        #2;
        chk("R10 restart after hold", step_oh, 32'h01);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_add();
        t_br();
        t_brn();
        t_unknown();
        t_hold();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule